// File: doc/BRIEF.md
# Leaf Power-Level Requester

This block is the bottom node of a tree-shaped power manager. It sits beside a single compute resource and takes a 3-bit demand code that names one of five ordered power levels. The level it currently applies is always visible on its outputs. When the demand moves away from that level, the block asks its parent for the demanded level. It then waits for a grant or a deny, acknowledges whichever arrives, and updates the applied level to match. A frequency code for the clock controller is derived from the applied level.

The block allows only one request in flight. Demand that changes while a request is open is not acted on at that point. It is compared again in the cycle after the acknowledge, so the most recent demand is always pursued. An optional step-down mode reacts to a denied upward request by asking again, one level lower each time, and gives up when the next level down would equal the level already held.

Top module: `pwr_leaf_client`

## Requirements
- R1: While reset is asserted and after it, until the first request: level_o is 0 (Low), pending_o, req_o and ack_o are 0, and freq_code_o is 14.
- R2: When the clamped demand equals level_o and nothing is pending, no request is issued and pending_o stays 0.
- R3: When not pending and the clamped demand differs from level_o at a clock edge, req_o is high for exactly the following cycle, req_lvl_o carries the demanded level, and pending_o becomes 1.
- R4: While pending with no grant or deny, demand changes cause no request and no acknowledge, and level_o and req_lvl_o hold.
- R5: A grant sampled while pending causes ack_o to be high for the next cycle only, level_o to take the requested level, and pending_o to clear.
- R6: A deny sampled while pending (step-down mode off) causes a one-cycle ack_o, leaves level_o unchanged and clears pending_o.
- R7: With step_down_en_i high, a deny of a request for level T where T > level_o + 1 causes ack_o and a new req_o for T-1 in the same cycle, with pending_o kept at 1. Otherwise the deny behaves as in R6.
- R8: A grant or deny arriving while not pending is ignored: no ack_o, and level_o is unchanged.
- R9: freq_code_o gives the clock frequency in units of 100 MHz for level_o, in the same cycle: 0 gives 14, 1 gives 21, 2 gives 27, 3 gives 33, 4 gives 36.
- R10: Demand codes 5 to 7 are treated as level 4 (High). level_o and req_lvl_o never exceed 4.
- R11: Demand that changed while pending is compared again at the edge after the acknowledge edge, so a resulting req_o appears in the cycle directly after ack_o.
- R12: If grant and deny are sampled together while pending, the grant takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demand_i | input | 3 | Demanded level: 0 Low to 4 High, 5 to 7 clamp to High |
| step_down_en_i | input | 1 | Enables step-down retry after a deny |
| grant_i | input | 1 | Single-cycle grant from the parent |
| deny_i | input | 1 | Single-cycle deny from the parent |
| req_o | output | 1 | Single-cycle request pulse to the parent |
| req_lvl_o | output | 3 | Level requested; valid while pending |
| ack_o | output | 1 | Single-cycle acknowledge of a response |
| pending_o | output | 1 | A request is open |
| level_o | output | 3 | Applied power level |
| freq_code_o | output | 6 | Frequency for level_o in units of 100 MHz |

## Verification
A corrupted target register shows up on level_o in the cycle after a grant, and on req_lvl_o as soon as a request or a step-down retry goes out. A pending flag stuck at 0 turns the next parent response into a missing ack_o one cycle later. A pending flag stuck at 1 shows as a repeated or missing req_o when demand changes. Because the parent only ever sees the request and acknowledge traffic, the bench compares every req_o level, in order, against a queue of expected levels. It also checks ack_o and level_o in the single cycle after each response.

// File: rtl/pwr_leaf_pkg.sv
package pwr_leaf_pkg;
  localparam int LVL_W  = 3;
  localparam int FREQ_W = 6;

  typedef enum logic [LVL_W-1:0] {
    LVL_LO = 3'd0,
    LVL_ML = 3'd1,
    LVL_MD = 3'd2,
    LVL_MH = 3'd3,
    LVL_HI = 3'd4
  } lvl_e;

  // frequency in 100 MHz units
  function automatic logic [FREQ_W-1:0] freq_of(lvl_e l);
    logic [FREQ_W-1:0] f;
    case (l)
      LVL_LO:  f = FREQ_W'(14);
      LVL_ML:  f = FREQ_W'(21);
      LVL_MD:  f = FREQ_W'(27);
      LVL_MH:  f = FREQ_W'(33);
      default: f = FREQ_W'(36);
    endcase
    return f;
  endfunction
endpackage

// File: rtl/pwr_demand_clamp.sv
module pwr_demand_clamp
  import pwr_leaf_pkg::*;
#(
  parameter int RAW_W = LVL_W
) (
  input  logic [RAW_W-1:0] raw_i,
  output lvl_e             lvl_o
);
  always_comb begin
    if (raw_i > RAW_W'(LVL_HI)) lvl_o = LVL_HI;
    else                        lvl_o = lvl_e'(raw_i[LVL_W-1:0]);
  end
endmodule

// File: rtl/pwr_freq_map.sv
module pwr_freq_map
  import pwr_leaf_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lvl_e              lvl_i,
  output logic [FREQ_W-1:0] freq_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [FREQ_W-1:0] freq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) freq_q <= freq_of(LVL_LO);
        else         freq_q <= freq_of(lvl_i);
      end
      assign freq_o = freq_q;
    end else begin : g_comb
      assign freq_o = freq_of(lvl_i);
    end
  endgenerate
endmodule

// File: rtl/pwr_leaf_fsm.sv
module pwr_leaf_fsm
  import pwr_leaf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e dem_i,
  input  logic step_en_i,
  input  logic grant_i,
  input  logic deny_i,
  output logic req_o,
  output lvl_e tgt_o,
  output logic ack_o,
  output logic pend_o,
  output lvl_e lvl_o
);
  lvl_e lvl_q, tgt_q;
  logic pend_q, req_q, ack_q;
  logic retry;

  // step down only for upward requests more than one level above current
  assign retry = step_en_i &&
                 ({1'b0, tgt_q} > ({1'b0, lvl_q} + (LVL_W+1)'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_LO;
      tgt_q  <= LVL_LO;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      if (!pend_q) begin
        if (dem_i != lvl_q) begin
          req_q  <= 1'b1;
          tgt_q  <= dem_i;
          pend_q <= 1'b1;
        end
      end else if (grant_i) begin
        ack_q  <= 1'b1;
        lvl_q  <= tgt_q;
        pend_q <= 1'b0;
      end else if (deny_i) begin
        ack_q <= 1'b1;
        if (retry) begin
          tgt_q <= lvl_e'(tgt_q - LVL_W'(1));
          req_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  assign req_o  = req_q;
  assign tgt_o  = tgt_q;
  assign ack_o  = ack_q;
  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/pwr_leaf_client.sv
module pwr_leaf_client
  import pwr_leaf_pkg::*;
#(
  parameter bit FREQ_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  demand_i,
  input  logic              step_down_en_i,
  input  logic              grant_i,
  input  logic              deny_i,
  output logic              req_o,
  output logic [LVL_W-1:0]  req_lvl_o,
  output logic              ack_o,
  output logic              pending_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [FREQ_W-1:0] freq_code_o
);
  lvl_e dem, tgt, lvl;

  pwr_demand_clamp #(.RAW_W(LVL_W)) u_clamp (
    .raw_i (demand_i),
    .lvl_o (dem)
  );

  pwr_leaf_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dem_i     (dem),
    .step_en_i (step_down_en_i),
    .grant_i   (grant_i),
    .deny_i    (deny_i),
    .req_o     (req_o),
    .tgt_o     (tgt),
    .ack_o     (ack_o),
    .pend_o    (pending_o),
    .lvl_o     (lvl)
  );

  pwr_freq_map #(.REG_OUT(FREQ_REG)) u_freq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .freq_o (freq_code_o)
  );

  assign req_lvl_o = tgt;
  assign level_o   = lvl;
endmodule

// File: rtl/pwr_leaf_client_chk.sv
module pwr_leaf_client_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_down_en_i,
  input logic       grant_i,
  input logic       deny_i,
  input logic       req_o,
  input logic [2:0] req_lvl_o,
  input logic       ack_o,
  input logic       pending_o,
  input logic [2:0] level_o
);
  assert_req_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_o) |-> req_o);

  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !deny_i |=> !req_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !grant_i && !deny_i |=> !req_o && !ack_o &&
      $stable(level_o) && $stable(req_lvl_o));

  assert_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && grant_i |=> ack_o && !pending_o && level_o == $past(req_lvl_o));

  assert_deny_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && deny_i && !grant_i && !step_down_en_i |=>
      ack_o && !pending_o && $stable(level_o));

  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o && (grant_i || deny_i) |=> !ack_o && $stable(level_o));

  assert_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 3'd4 && req_lvl_o <= 3'd4);
endmodule

bind pwr_leaf_client pwr_leaf_client_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .step_down_en_i (step_down_en_i),
  .grant_i        (grant_i),
  .deny_i         (deny_i),
  .req_o          (req_o),
  .req_lvl_o      (req_lvl_o),
  .ack_o          (ack_o),
  .pending_o      (pending_o),
  .level_o        (level_o)
);

// File: tb/sim_pwr_leaf_client.sv
`timescale 1ns/1ps
module sim_pwr_leaf_client;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] demand_i;
  logic       step_down_en_i, grant_i, deny_i;
  logic       req_o, ack_o, pending_o;
  logic [2:0] req_lvl_o, level_o;
  logic [5:0] freq_code_o;

  int checks = 0;
  int failures = 0;
  int req_seen = 0;
  int exp_q[$];

  always #2 clk_i = ~clk_i;

  pwr_leaf_client u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .demand_i (demand_i),
    .step_down_en_i (step_down_en_i), .grant_i (grant_i), .deny_i (deny_i),
    .req_o (req_o), .req_lvl_o (req_lvl_o), .ack_o (ack_o),
    .pending_o (pending_o), .level_o (level_o), .freq_code_o (freq_code_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: every request is compared against the scoreboard queue
  always @(negedge clk_i) begin
    int e;
    if (rst_ni && req_o) begin
      req_seen++;
      if (exp_q.size() == 0) chk("R4 unexpected request", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R3 request level", int'(req_lvl_o), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; demand_i = 3'd0; step_down_en_i = 1'b0;
    grant_i = 1'b0; deny_i = 1'b0;
    cyc(3);
    chk("R1 level", level_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 req", req_o, 0);
    chk("R1 ack", ack_o, 0);
    chk("R1 freq", freq_code_o, 14);
    rst_ni = 1'b1;

    cyc(3);
    chk("R2 no request", req_seen, 0);
    chk("R2 pending", pending_o, 0);

    demand_i = 3'd3; exp_q.push_back(3);
    cyc(1);
    chk("R3 req high", req_o, 1);
    chk("R3 pending", pending_o, 1);
    cyc(1);
    chk("R3 req single pulse", req_o, 0);

    demand_i = 3'd1;
    cyc(3);
    chk("R4 level held", level_o, 0);
    chk("R4 still pending", pending_o, 1);
    chk("R4 req count", req_seen, 1);
    chk("R4 no ack", ack_o, 0);

    grant_i = 1'b1; exp_q.push_back(1);
    cyc(1);
    grant_i = 1'b0;
    chk("R5 ack", ack_o, 1);
    chk("R5 level", level_o, 3);
    chk("R5 pending clear", pending_o, 0);
    chk("R9 freq MH", freq_code_o, 33);
    cyc(1);
    chk("R11 resampled req", req_o, 1);
    chk("R5 ack single pulse", ack_o, 0);

    deny_i = 1'b1;
    cyc(1);
    deny_i = 1'b0; demand_i = 3'd3;
    chk("R6 ack", ack_o, 1);
    chk("R6 level kept", level_o, 3);
    chk("R6 pending clear", pending_o, 0);
    cyc(2);
    chk("R2 no new request", req_seen, 2);

    grant_i = 1'b1;
    cyc(1);
    grant_i = 1'b0;
    chk("R8 grant ignored ack", ack_o, 0);
    chk("R8 grant ignored level", level_o, 3);
    deny_i = 1'b1;
    cyc(1);
    deny_i = 1'b0;
    chk("R8 deny ignored ack", ack_o, 0);
    chk("R8 deny ignored level", level_o, 3);

    demand_i = 3'd6; exp_q.push_back(4);
    cyc(1);
    grant_i = 1'b1;
    cyc(1);
    grant_i = 1'b0;
    chk("R10 clamped level", level_o, 4);
    chk("R9 freq H", freq_code_o, 36);
    cyc(2);
    chk("R10 no re-request", pending_o, 0);

    demand_i = 3'd0; exp_q.push_back(0);
    cyc(1);
    grant_i = 1'b1;
    cyc(1);
    grant_i = 1'b0;
    chk("R9 freq L", freq_code_o, 14);
    step_down_en_i = 1'b1;
    demand_i = 3'd3; exp_q.push_back(3);
    cyc(1);
    deny_i = 1'b1; exp_q.push_back(2);
    cyc(1);
    chk("R7 ack", ack_o, 1);
    chk("R7 retry req", req_o, 1);
    chk("R7 pending kept", pending_o, 1);
    chk("R7 level", level_o, 0);
    exp_q.push_back(1);
    cyc(1);
    chk("R7 second retry", req_o, 1);
    cyc(1);
    deny_i = 1'b0; demand_i = 3'd0;
    chk("R7 final ack", ack_o, 1);
    chk("R7 no retry to held level", req_o, 0);
    chk("R7 pending clear", pending_o, 0);
    chk("R7 level", level_o, 0);
    cyc(2);

    step_down_en_i = 1'b0;
    demand_i = 3'd2; exp_q.push_back(2);
    cyc(1);
    grant_i = 1'b1; deny_i = 1'b1;
    cyc(1);
    grant_i = 1'b0; deny_i = 1'b0;
    chk("R12 grant wins", level_o, 2);
    chk("R12 ack", ack_o, 1);
    chk("R9 freq M", freq_code_o, 27);

    demand_i = 3'd1; exp_q.push_back(1);
    cyc(1);
    grant_i = 1'b1;
    cyc(1);
    grant_i = 1'b0;
    chk("R9 freq ML", freq_code_o, 21);
    cyc(2);
    chk("R3 all requests seen", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule